// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block tracks a single cache-line reservation so that a requester can pair a reserving read with a conditional write. Requests arrive one per cycle on a request port and are either refused (downstream busy), rejected (conditional write without a valid reservation), or accepted and forwarded to the cache as a command. The reservation is armed only when a reserving read reports completion on a separate completion port. It is disarmed by a successful conditional write, by a snooped external write or invalidation of the line, or by a plain store from a different requester to that line.

The conditional-write check and the forwarding decision are made in the same cycle against the reservation state held at the start of that cycle, so nothing can reach the cache between the check and the store. Each request receives a registered result one cycle later: success, busy, or failure, with failure and busy encoded differently. Data movement and the coherence protocol live elsewhere.

Top module: `rsv_mon`

## Requirements
- R1: After reset no reservation is held and both output valids are low; a conditional write issued first after reset fails.
- R2: A reservation (line address and requester ID) is recorded only by an asserted completion; issuing a reserving read does not arm it, and a conditional write before the completion fails.
- R3: A conditional write (kind 2'b11) whose line and ID match the held reservation returns code 2'b00 the next cycle and is forwarded as a store (issue_wr=1) with its full address and ID.
- R4: A successful conditional write clears the reservation, so a repeat of the same conditional write fails.
- R5: A conditional write whose line or ID differs returns code 2'b10 (the minus-two failure), issues nothing, and leaves the reservation untouched.
- R6: A request presented while dn_busy is high returns code 2'b11 (the minus-one refusal), issues nothing and changes no reservation state; busy takes precedence over the failure code.
- R7: A snoop to the reserved line clears the reservation; a snoop to any other line has no effect.
- R8: An accepted plain store (kind 2'b01) from a requester other than the owner to the reserved line clears the reservation; owner stores and stores to other lines do not.
- R9: A new completion replaces any held reservation, including its owner ID.
- R10: In one cycle, a completion wins over every clearing event, and a conditional write is judged against the reservation held before that cycle's update.
- R11: Loads (2'b00), stores (2'b01) and reserving reads (2'b10) are forwarded with code 2'b00; issue_wr is 0 only for loads; line matching ignores the low LINE_OFS address bits; every request yields exactly one result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 load, 01 store, 10 reserving read, 11 conditional write |
| req_addr | input | ADDR_W | Byte address of the request |
| req_id | input | ID_W | Requester ID |
| dn_busy | input | 1 | Downstream cannot take a command |
| cpl_valid | input | 1 | A reserving read completed |
| cpl_line | input | ADDR_W-LINE_OFS | Line address of the completed read |
| cpl_id | input | ID_W | Requester of the completed read |
| snp_valid | input | 1 | External write or invalidation observed |
| snp_line | input | ADDR_W-LINE_OFS | Line address of the snoop |
| issue_valid | output | 1 | Command forwarded to the cache |
| issue_wr | output | 1 | Forwarded command is a store |
| issue_addr | output | ADDR_W | Forwarded byte address |
| issue_id | output | ID_W | Forwarded requester ID |
| resp_valid | output | 1 | Result for last cycle's request |
| resp_code | output | 2 | 00 success, 11 busy, 10 conditional failure |

## Verification
Every result of a request, both the forwarded command and the response code, is due exactly one clock edge after the request is presented, and a completion or snoop changes the reservation at that same edge, so its effect shows on the next request's result. The bench drives one cycle's inputs after a falling edge, predicts the outcome from its own reservation model as it stood before the rising edge, and compares the registered outputs at the following falling edge. Reservation state is observed only through later conditional writes, which is how the no-effect cases are checked.

// File: rtl/rsv_mon_pkg.sv
package rsv_mon_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD    = 2'b00,
    KIND_STORE   = 2'b01,
    KIND_LOCK_RD = 2'b10,
    KIND_LOCK_WR = 2'b11
  } kind_e;

  localparam logic [1:0] CODE_OK   = 2'b00;
  localparam logic [1:0] CODE_FAIL = 2'b10;
  localparam logic [1:0] CODE_BUSY = 2'b11;
endpackage

// File: rtl/rsv_mon_cmp.sv
module rsv_mon_cmp #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              rsv_vld,
  input  logic [LINE_W-1:0] rsv_line,
  input  logic [ID_W-1:0]   rsv_id,
  input  logic [LINE_W-1:0] probe_line,
  input  logic [ID_W-1:0]   probe_id,
  output logic              line_hit,
  output logic              own_hit
);
  always_comb begin
    line_hit = rsv_vld && (probe_line == rsv_line);
    own_hit  = line_hit && (probe_id == rsv_id);
  end
endmodule

// File: rtl/rsv_mon_reg.sv
module rsv_mon_reg #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_line,
  input  logic [ID_W-1:0]   set_id,
  input  logic              clr_en,
  output logic              vld_q,
  output logic [LINE_W-1:0] line_q,
  output logic [ID_W-1:0]   id_q
);
  logic vld_d;
  logic ld_en;

  // set has priority over any clear in the same cycle
  always_comb begin
    ld_en = set_en;
    if (set_en)      vld_d = 1'b1;
    else if (clr_en) vld_d = 1'b0;
    else             vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      line_q <= '0;
      id_q   <= '0;
    end else begin
      vld_q <= vld_d;
      if (ld_en) begin
        line_q <= set_line;
        id_q   <= set_id;
      end
    end
  end
endmodule

// File: rtl/rsv_mon_decide.sv
module rsv_mon_decide
  import rsv_mon_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       dn_busy,
  input  logic       line_hit,
  input  logic       own_hit,
  output logic       fwd,
  output logic       fwd_wr,
  output logic [1:0] code,
  output logic       win_clr,
  output logic       foreign_clr
);
  logic accept;
  logic is_cond;
  logic is_store;

  always_comb begin
    accept   = req_valid && !dn_busy;
    is_cond  = (req_kind == KIND_LOCK_WR);
    is_store = (req_kind == KIND_STORE);
    fwd_wr   = (req_kind != KIND_LOAD);

    if (dn_busy)                 code = CODE_BUSY;
    else if (is_cond && !own_hit) code = CODE_FAIL;
    else                         code = CODE_OK;

    fwd         = accept && !(is_cond && !own_hit);
    win_clr     = accept && is_cond && own_hit;
    foreign_clr = accept && is_store && line_hit && !own_hit;
  end
endmodule

// File: rtl/rsv_mon.sv
module rsv_mon
  import rsv_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int ID_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_kind,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [ID_W-1:0]            req_id,
  input  logic                       dn_busy,
  input  logic                       cpl_valid,
  input  logic [ADDR_W-LINE_OFS-1:0] cpl_line,
  input  logic [ID_W-1:0]            cpl_id,
  input  logic                       snp_valid,
  input  logic [ADDR_W-LINE_OFS-1:0] snp_line,
  output logic                       issue_valid,
  output logic                       issue_wr,
  output logic [ADDR_W-1:0]          issue_addr,
  output logic [ID_W-1:0]            issue_id,
  output logic                       resp_valid,
  output logic [1:0]                 resp_code
);
  localparam int LINE_W = ADDR_W - LINE_OFS;

  logic              rsv_vld;
  logic [LINE_W-1:0] rsv_line;
  logic [ID_W-1:0]   rsv_id;
  logic              line_hit, own_hit, snp_hit;
  logic              fwd, fwd_wr, win_clr, foreign_clr, clr_any;
  logic [1:0]        code;

  rsv_mon_cmp #(.LINE_W(LINE_W), .ID_W(ID_W)) u_cmp (
    .rsv_vld(rsv_vld), .rsv_line(rsv_line), .rsv_id(rsv_id),
    .probe_line(req_addr[ADDR_W-1:LINE_OFS]), .probe_id(req_id),
    .line_hit(line_hit), .own_hit(own_hit)
  );

  rsv_mon_decide u_dec (
    .req_valid(req_valid), .req_kind(req_kind), .dn_busy(dn_busy),
    .line_hit(line_hit), .own_hit(own_hit),
    .fwd(fwd), .fwd_wr(fwd_wr), .code(code),
    .win_clr(win_clr), .foreign_clr(foreign_clr)
  );

  always_comb begin
    snp_hit = snp_valid && rsv_vld && (snp_line == rsv_line);
    clr_any = win_clr || foreign_clr || snp_hit;
  end

  rsv_mon_reg #(.LINE_W(LINE_W), .ID_W(ID_W)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .set_en(cpl_valid), .set_line(cpl_line), .set_id(cpl_id),
    .clr_en(clr_any),
    .vld_q(rsv_vld), .line_q(rsv_line), .id_q(rsv_id)
  );

  // registered result and command
  logic              iss_v_d, rsp_v_d, out_ld;
  logic [1:0]        code_d;

  always_comb begin
    iss_v_d = fwd;
    rsp_v_d = req_valid;
    code_d  = req_valid ? code : CODE_OK;
    out_ld  = fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      resp_valid  <= 1'b0;
      resp_code   <= CODE_OK;
      issue_wr    <= 1'b0;
      issue_addr  <= '0;
      issue_id    <= '0;
    end else begin
      issue_valid <= iss_v_d;
      resp_valid  <= rsp_v_d;
      resp_code   <= code_d;
      if (out_ld) begin
        issue_wr   <= fwd_wr;
        issue_addr <= req_addr;
        issue_id   <= req_id;
      end
    end
  end
endmodule

// File: rtl/rsv_mon_chk.sv
module rsv_mon_chk
  import rsv_mon_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              dn_busy,
  input logic              cpl_valid,
  input logic              snp_valid,
  input logic [LINE_W-1:0] snp_line,
  input logic              issue_valid,
  input logic              resp_valid,
  input logic [1:0]        resp_code,
  input logic              rsv_vld,
  input logic [LINE_W-1:0] rsv_line
);
  // R6
  busy_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dn_busy) |=> (resp_valid && resp_code == CODE_BUSY && !issue_valid));

  // R5
  fail_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == CODE_FAIL) |-> !issue_valid);

  // R3
  issue_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (resp_valid && resp_code == CODE_OK));

  // R2
  rsv_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> rsv_vld);

  // R7
  snoop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !cpl_valid && rsv_vld && snp_line == rsv_line) |=> !rsv_vld);

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R11
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
endmodule

bind rsv_mon rsv_mon_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dn_busy(dn_busy),
  .cpl_valid(cpl_valid), .snp_valid(snp_valid), .snp_line(snp_line),
  .issue_valid(issue_valid), .resp_valid(resp_valid), .resp_code(resp_code),
  .rsv_vld(rsv_vld), .rsv_line(rsv_line)
);

// File: tb/test_rsv_mon.sv
module test_rsv_mon;
  localparam int AW = 32;
  localparam int LO = 6;
  localparam int IW = 4;
  localparam int LW = AW - LO;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [IW-1:0] req_id;
  logic          dn_busy;
  logic          cpl_valid;
  logic [LW-1:0] cpl_line;
  logic [IW-1:0] cpl_id;
  logic          snp_valid;
  logic [LW-1:0] snp_line;
  logic          issue_valid, issue_wr, resp_valid;
  logic [AW-1:0] issue_addr;
  logic [IW-1:0] issue_id;
  logic [1:0]    resp_code;

  rsv_mon #(.ADDR_W(AW), .LINE_OFS(LO), .ID_W(IW)) i_rsv_mon (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural reservation model
  bit            m_vld = 1'b0;
  logic [LW-1:0] m_line = '0;
  logic [IW-1:0] m_id = '0;

  task automatic cyc(input bit rv, input logic [1:0] k, input logic [AW-1:0] a,
                     input logic [IW-1:0] id, input bit bz, input bit cv,
                     input logic [LW-1:0] cl, input logic [IW-1:0] ci,
                     input bit sv, input logic [LW-1:0] sl, input string tag);
    bit own, lhit, eiss, clr;
    logic [1:0] ecode;
    logic [AW+IW+5:0] got, exp;
    req_valid = rv; req_kind = k; req_addr = a; req_id = id; dn_busy = bz;
    cpl_valid = cv; cpl_line = cl; cpl_id = ci; snp_valid = sv; snp_line = sl;
    lhit = m_vld && (a[AW-1:LO] == m_line);
    own  = lhit && (id == m_id);
    if (bz) begin ecode = 2'b11; eiss = 1'b0; end
    else if (k == 2'b11 && !own) begin ecode = 2'b10; eiss = 1'b0; end
    else begin ecode = 2'b00; eiss = rv; end
    clr = (rv && !bz && k == 2'b11 && own) ||
          (rv && !bz && k == 2'b01 && lhit && !own) ||
          (sv && m_vld && sl == m_line);
    @(posedge clk);
    @(negedge clk);
    if (cv) begin m_vld = 1'b1; m_line = cl; m_id = ci; end
    else if (clr) m_vld = 1'b0;
    exp = {rv, rv ? ecode : 2'b00, eiss, eiss ? {(k != 2'b00), a, id} : {1'b0, {AW{1'b0}}, {IW{1'b0}}}};
    got = {resp_valid, resp_valid ? resp_code : 2'b00, issue_valid,
           issue_valid ? {issue_wr, issue_addr, issue_id} : {1'b0, {AW{1'b0}}, {IW{1'b0}}}};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input string tag);
    cyc(0, 2'b00, '0, '0, 0, 0, '0, '0, 0, '0, tag);
  endtask
  task automatic rq(input logic [1:0] k, input logic [AW-1:0] a, input logic [IW-1:0] id,
                    input bit bz, input string tag);
    cyc(1, k, a, id, bz, 0, '0, '0, 0, '0, tag);
  endtask
  task automatic cpl(input logic [LW-1:0] l, input logic [IW-1:0] id, input string tag);
    cyc(0, 2'b00, '0, '0, 0, 1, l, id, 0, '0, tag);
  endtask
  task automatic snp(input logic [LW-1:0] l, input string tag);
    cyc(0, 2'b00, '0, '0, 0, 0, '0, '0, 1, l, tag);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_kind = 0; req_addr = 0; req_id = 0; dn_busy = 0;
    cpl_valid = 0; cpl_line = 0; cpl_id = 0; snp_valid = 0; snp_line = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (resp_valid !== 1'b0 || issue_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: actual %b%b expected 00", resp_valid, issue_valid);
    end
    rst_n = 1'b1;
    idle("R1");
    rq(2'b11, 32'h1000, 4'd1, 0, "R1");          // no reservation yet
    rq(2'b10, 32'h1000, 4'd1, 0, "R11");         // reserving read forwarded
    rq(2'b11, 32'h1000, 4'd1, 0, "R2");          // not armed before completion
    cpl(26'h40, 4'd1, "R2");
    rq(2'b11, 32'h1000, 4'd2, 0, "R5");          // wrong ID
    rq(2'b11, 32'h2000, 4'd1, 0, "R5");          // wrong line
    rq(2'b11, 32'h1000, 4'd1, 1, "R6");          // busy, kept
    rq(2'b11, 32'h1008, 4'd1, 0, "R3");          // offset ignored, success
    rq(2'b11, 32'h1000, 4'd1, 0, "R4");          // consumed
    cpl(26'h40, 4'd1, "R7");
    snp(26'h41, "R7");                           // other line ignored
    rq(2'b11, 32'h1000, 4'd1, 0, "R7");
    cpl(26'h40, 4'd1, "R7");
    snp(26'h40, "R7");
    rq(2'b11, 32'h1000, 4'd1, 0, "R7");          // cleared by snoop
    cpl(26'h40, 4'd1, "R8");
    rq(2'b01, 32'h1004, 4'd1, 0, "R8");          // owner store
    rq(2'b01, 32'h2000, 4'd2, 0, "R8");          // other line
    rq(2'b01, 32'h1010, 4'd2, 1, "R6");          // busy store has no effect
    rq(2'b11, 32'h1000, 4'd1, 0, "R8");
    cpl(26'h40, 4'd1, "R8");
    rq(2'b01, 32'h1010, 4'd2, 0, "R8");          // foreign store clears
    rq(2'b11, 32'h1000, 4'd1, 0, "R8");
    cpl(26'h40, 4'd1, "R9");
    cpl(26'h80, 4'd2, "R9");
    rq(2'b11, 32'h1000, 4'd1, 0, "R9");
    rq(2'b11, 32'h2000, 4'd2, 0, "R9");
    cyc(0, 2'b00, '0, '0, 0, 1, 26'h40, 4'd3, 1, 26'h40, "R10");
    rq(2'b11, 32'h1000, 4'd3, 0, "R10");
    cyc(1, 2'b11, 32'h1000, 4'd3, 0, 1, 26'h40, 4'd1, 0, '0, "R10");
    rq(2'b11, 32'h1000, 4'd1, 0, "R10");
    rq(2'b00, 32'h3004, 4'd5, 0, "R11");
    rq(2'b01, 32'h3008, 4'd6, 0, "R11");
    rq(2'b00, 32'h3004, 4'd5, 1, "R6");
    idle("R11");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule